// File: doc/BRIEF.md
# Serial Real-Time-Clock Register Slave

This block is the device side of a small real-time-clock register bank that a host reaches over a four-wire bit-serial link. The four wires are enable, serial clock, data-in and data-out. All three host lines are brought into the block's clock domain through a short synchronizer. The rising edges of the serial clock are found after that synchronizer. A frame opens when enable is raised. Every frame that completes is 36 serial clock pulses long.

A write frame carries the data word first, then the register address, then a direction bit of one. A read frame carries the address first, then a direction bit of zero, and after that the addressed word comes back on data-out. The bank has a seconds counter that a one-cycle tick advances, a seconds-adjust word, and four general-purpose storage words. A ready output tells the host when a new frame may begin.

Each host line level must be held for at least three system clock cycles. The host must keep data-in low while read data is being returned.

Top module: `rtc_ser_slave`

## Requirements
- R1: After reset, ready is high, data-out is low, and every register (the seconds counter, the adjust word and the storage words) reads zero.
- R2: A write frame is 32 data bits (most significant first), 3 address bits (most significant first), and a direction bit of 1 on the 36th pulse. That bit stores the data in the addressed register: address 0 is the seconds counter, address 2 the adjust word, and addresses 4 to 7 the storage words.
- R3: A read frame is 3 address bits (most significant first) and a direction bit of 0 on the 4th pulse. On rising edges 5 through 36, data-out presents bits 31 down to 0 of the addressed register, each bit valid after the edge that produces it.
- R4: Data-out is low whenever enable is low.
- R5: Each tick pulse adds one to the seconds counter, and the counter wraps from 0xFFFFFFFF to 0.
- R6: When a write to address 0 commits in the same cycle as a tick, the counter takes the written value and the tick is lost.
- R7: Dropping enable before the 36th pulse abandons the frame, and no register changes.
- R8: Addresses 1 and 3 always read as zero, and writes to them are discarded.
- R9: Ready goes low when enable is raised. It returns high after the 36th pulse while enable is still high. Any further pulses before enable drops are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| ser_en_i | input | 1 | Frame enable from host |
| ser_clk_i | input | 1 | Serial clock from host |
| ser_din_i | input | 1 | Serial data from host |
| ser_dout_o | output | 1 | Serial read data to host |
| ready_o | output | 1 | High when a new frame may start |

## Verification
The hardest case to reach is a tick that lands in exactly the cycle where a counter write commits. The commit happens two synchronizer stages and one edge-detect register after the host raises the serial clock for the direction bit. The bench counts those cycles from the moment it drives that edge. It pulses the tick so that the pulse covers only the commit cycle, then reads the counter back. A counter one higher than the written value would expose a wrong priority.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;

  typedef enum logic [1:0] {
    LINK_IDLE,
    LINK_SHIFT,
    LINK_DONE
  } link_state_e;

  localparam int unsigned REG_SECONDS = 0;
  localparam int unsigned REG_ADJUST  = 2;
  localparam int unsigned REG_GP_BASE = 4;

endpackage

// File: rtl/rtc_ser_sync.sv
module rtc_ser_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rtc_ser_frame.sv
module rtc_ser_frame
  import rtc_ser_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              ready_o,
  output logic              dout_o
);

  localparam int unsigned FRAME_LEN = DATA_W + ADDR_W + 1;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);

  link_state_e         state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [FRAME_LEN-2:0] sh_q, sh_d;
  logic [DATA_W-1:0]   rd_sh_q, rd_sh_d;
  logic                rd_act_q, rd_act_d;
  logic                dout_q, dout_d;
  logic                sclk_q;

  logic                 sclk_rise;
  logic                 take;
  logic                 at_last;
  logic                 at_dir_rd;
  logic                 rd_go;
  logic [FRAME_LEN-1:0] shift_nxt;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign shift_nxt = {sh_q, din_i};
  assign take      = (state_q == LINK_SHIFT) && en_i && sclk_rise;
  assign at_last   = (cnt_q == CNT_W'(FRAME_LEN - 1));
  assign at_dir_rd = (cnt_q == CNT_W'(ADDR_W));
  assign rd_go     = take && at_dir_rd && !din_i;

  // Direction bit of one on the final pulse commits the collected word.
  assign wr_en_o   = take && at_last && din_i;
  assign wr_addr_o = shift_nxt[ADDR_W:1];
  assign wr_data_o = shift_nxt[FRAME_LEN-1:ADDR_W+1];
  assign rd_addr_o = shift_nxt[ADDR_W:1];
  assign ready_o   = (state_q != LINK_SHIFT);
  assign dout_o    = dout_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rd_sh_d  = rd_sh_q;
    rd_act_d = rd_act_q;
    dout_d   = dout_q;
    unique case (state_q)
      LINK_IDLE: begin
        dout_d = 1'b0;
        if (en_i) begin
          state_d  = LINK_SHIFT;
          cnt_d    = '0;
          sh_d     = '0;
          rd_act_d = 1'b0;
        end
      end
      LINK_SHIFT: begin
        if (!en_i) begin
          state_d = LINK_IDLE;
          dout_d  = 1'b0;
        end else if (sclk_rise) begin
          cnt_d = cnt_q + CNT_W'(1);
          sh_d  = shift_nxt[FRAME_LEN-2:0];
          if (rd_go) begin
            rd_sh_d  = rd_data_i;
            rd_act_d = 1'b1;
          end else if (rd_act_q) begin
            dout_d  = rd_sh_q[DATA_W-1];
            rd_sh_d = {rd_sh_q[DATA_W-2:0], 1'b0};
          end
          if (at_last) state_d = LINK_DONE;
        end
      end
      LINK_DONE: begin
        if (!en_i) begin
          state_d = LINK_IDLE;
          dout_d  = 1'b0;
        end
      end
      default: state_d = LINK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LINK_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rd_sh_q  <= '0;
      rd_act_q <= 1'b0;
      dout_q   <= 1'b0;
      sclk_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rd_sh_q  <= rd_sh_d;
      rd_act_q <= rd_act_d;
      dout_q   <= dout_d;
      sclk_q   <= sclk_i;
    end
  end

  // R9: raising enable from idle takes ready low on the next cycle
  p_ready_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LINK_IDLE && en_i) |=> !ready_o);

  // R9: once the direction bit commits, the link is ready again
  p_ready_after_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> ready_o);

  // R4: enable low silences data-out by the next cycle
  p_dout_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !dout_o);

  // R3: data-out holds between serial clock edges
  p_dout_edge_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !sclk_rise && state_q != LINK_IDLE) |=> $stable(dout_o));

endmodule

// File: rtl/rtc_ser_regs.sv
module rtc_ser_regs
  import rtc_ser_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned NUM_GP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0]             secs_q, secs_d;
  logic [DATA_W-1:0]             adj_q, adj_d;
  logic [NUM_GP-1:0][DATA_W-1:0] gp_q, gp_d;
  logic [NUM_GP-1:0]             gp_hit;
  logic                          secs_hit;
  logic                          adj_hit;

  assign secs_hit = wr_en_i && (wr_addr_i == ADDR_W'(REG_SECONDS));
  assign adj_hit  = wr_en_i && (wr_addr_i == ADDR_W'(REG_ADJUST));

  for (genvar g = 0; g < int'(NUM_GP); g++) begin : g_gp_sel
    assign gp_hit[g] = wr_en_i && (wr_addr_i == ADDR_W'(REG_GP_BASE + g));
  end

  always_comb begin
    // A host load takes priority over the tick in the same cycle.
    if (secs_hit)    secs_d = wr_data_i;
    else if (tick_i) secs_d = secs_q + DATA_W'(1);
    else             secs_d = secs_q;
    adj_d = adj_hit ? wr_data_i : adj_q;
    for (int i = 0; i < int'(NUM_GP); i++) begin
      gp_d[i] = gp_hit[i] ? wr_data_i : gp_q[i];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(REG_SECONDS)) rd_data_o = secs_q;
    if (rd_addr_i == ADDR_W'(REG_ADJUST))  rd_data_o = adj_q;
    for (int i = 0; i < int'(NUM_GP); i++) begin
      if (rd_addr_i == ADDR_W'(REG_GP_BASE + i)) rd_data_o = gp_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q <= '0;
      adj_q  <= '0;
      gp_q   <= '0;
    end else begin
      secs_q <= secs_d;
      adj_q  <= adj_d;
      gp_q   <= gp_d;
    end
  end

  // R6: a counter load wins over a coincident tick
  p_load_beats_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == ADDR_W'(REG_SECONDS)) |=> (secs_q == $past(wr_data_i)));

  // R5: a tick with no load adds exactly one, wrapping at the top
  p_tick_adds_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !(wr_en_i && wr_addr_i == ADDR_W'(REG_SECONDS)))
      |=> (secs_q == $past(secs_q) + DATA_W'(1)));

  // R7: storage words move only on a committed write
  p_gp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(gp_q) && $stable(adj_q)));

  // R8: the two unmapped addresses read as zero
  p_hole_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == ADDR_W'(1) || rd_addr_i == ADDR_W'(3)) |-> (rd_data_o == '0));

endmodule

// File: rtl/rtc_ser_slave.sv
module rtc_ser_slave #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned NUM_GP      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ser_en_i,
  input  logic ser_clk_i,
  input  logic ser_din_i,
  output logic ser_dout_o,
  output logic ready_o
);

  localparam int unsigned LINE_W = 3;

  logic [LINE_W-1:0] lines_raw;
  logic [LINE_W-1:0] lines_sync;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  assign lines_raw = {ser_en_i, ser_clk_i, ser_din_i};

  rtc_ser_sync #(
    .WIDTH  (LINE_W),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lines_raw),
    .q_o   (lines_sync)
  );

  rtc_ser_frame #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) i_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (lines_sync[2]),
    .sclk_i    (lines_sync[1]),
    .din_i     (lines_sync[0]),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_addr_o (rd_addr),
    .ready_o   (ready_o),
    .dout_o    (ser_dout_o)
  );

  rtc_ser_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_GP (NUM_GP)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

endmodule

// File: tb/test_rtc_ser_slave.sv
module test_rtc_ser_slave;

  localparam int HALF = 6;
  localparam int NVEC = 15;

  logic clk;
  logic rst_n;
  logic tick_i;
  logic ser_en_i;
  logic ser_clk_i;
  logic ser_din_i;
  logic ser_dout_o;
  logic ready_o;

  int  n_checks;
  int  n_errors;
  bit  finished;

  rtc_ser_slave i_rtc_ser_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .ser_en_i   (ser_en_i),
    .ser_clk_i  (ser_clk_i),
    .ser_din_i  (ser_din_i),
    .ser_dout_o (ser_dout_o),
    .ready_o    (ready_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {write, addr[2:0], data[31:0], expected[31:0]}
  localparam logic [67:0] VEC [NVEC] = '{
    {1'b1, 3'd4, 32'hA5A5_0001, 32'h0},
    {1'b1, 3'd5, 32'h5A5A_0002, 32'h0},
    {1'b1, 3'd6, 32'h8000_0001, 32'h0},
    {1'b1, 3'd7, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 3'd2, 32'h0000_1234, 32'h0},
    {1'b1, 3'd1, 32'hDEAD_BEEF, 32'h0},
    {1'b1, 3'd3, 32'hCAFE_F00D, 32'h0},
    {1'b0, 3'd4, 32'h0, 32'hA5A5_0001},
    {1'b0, 3'd5, 32'h0, 32'h5A5A_0002},
    {1'b0, 3'd6, 32'h0, 32'h8000_0001},
    {1'b0, 3'd7, 32'h0, 32'hFFFF_FFFF},
    {1'b0, 3'd2, 32'h0, 32'h0000_1234},
    {1'b0, 3'd1, 32'h0, 32'h0},
    {1'b0, 3'd3, 32'h0, 32'h0},
    {1'b0, 3'd0, 32'h0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    ser_din_i = b;
    ser_clk_i = 1'b0;
    half_wait();
    ser_clk_i = 1'b1;
    half_wait();
  endtask

  task automatic open_frame();
    ser_clk_i = 1'b0;
    ser_en_i  = 1'b1;
    half_wait();
  endtask

  task automatic close_frame();
    ser_clk_i = 1'b0;
    ser_din_i = 1'b0;
    half_wait();
    ser_en_i = 1'b0;
    half_wait();
    half_wait();
  endtask

  task automatic send_body(input logic [2:0] addr, input logic [31:0] data);
    for (int i = 31; i >= 0; i--) pulse(data[i]);
    for (int i = 2; i >= 0; i--) pulse(addr[i]);
  endtask

  task automatic do_write(input logic [2:0] addr, input logic [31:0] data);
    open_frame();
    send_body(addr, data);
    pulse(1'b1);
    close_frame();
  endtask

  task automatic do_read(input logic [2:0] addr, output logic [31:0] data);
    data = '0;
    open_frame();
    for (int i = 2; i >= 0; i--) pulse(addr[i]);
    pulse(1'b0);
    for (int i = 0; i < 32; i++) begin
      pulse(1'b0);
      data = {data[30:0], ser_dout_o};
    end
    close_frame();
  endtask

  task automatic tick_once();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL R9: watchdog expired, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    tick_i = 1'b0;
    ser_en_i = 1'b0;
    ser_clk_i = 1'b0;
    ser_din_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    check("R1 ready", 32'(ready_o), 32'd1);
    check("R1 dout", 32'(ser_dout_o), 32'd0);
    do_read(3'd4, rd);
    check("R1 storage zero", rd, 32'h0);
    do_read(3'd2, rd);
    check("R1 adjust zero", rd, 32'h0);

    // R2 R3 R8: vector walk of writes then reads
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][67]) begin
        do_write(VEC[v][66:64], VEC[v][63:32]);
      end else begin
        do_read(VEC[v][66:64], rd);
        if (VEC[v][66:64] == 3'd1 || VEC[v][66:64] == 3'd3)
          check("R8 hole address", rd, VEC[v][31:0]);
        else
          check("R2 R3 readback", rd, VEC[v][31:0]);
      end
    end

    // R4: data-out low after a read once enable is down
    check("R4 dout idle", 32'(ser_dout_o), 32'd0);

    // R7: abandoned write leaves storage word 4 intact
    open_frame();
    for (int i = 0; i < 20; i++) pulse(i[0]);
    close_frame();
    do_read(3'd4, rd);
    check("R7 abort", rd, 32'hA5A5_0001);

    // R9: ready behaviour and pulses after the frame end
    open_frame();
    check("R9 ready low in frame", 32'(ready_o), 32'd0);
    send_body(3'd7, 32'h0F0F_0F0F);
    pulse(1'b1);
    check("R9 ready high after frame", 32'(ready_o), 32'd1);
    for (int i = 0; i < 5; i++) pulse(1'b1);
    check("R9 ready stays high", 32'(ready_o), 32'd1);
    close_frame();
    do_read(3'd7, rd);
    check("R9 extra pulses ignored", rd, 32'h0F0F_0F0F);
    do_read(3'd6, rd);
    check("R2 neighbour untouched", rd, 32'h8000_0001);

    // R5: ticks and wrap
    do_write(3'd0, 32'hFFFF_FFFE);
    tick_once();
    tick_once();
    tick_once();
    do_read(3'd0, rd);
    check("R5 tick wrap", rd, 32'h0000_0001);
    tick_once();
    tick_once();
    do_read(3'd0, rd);
    check("R5 tick count", rd, 32'h0000_0003);

    // R6: tick lands exactly in the commit cycle of a counter load
    open_frame();
    send_body(3'd0, 32'h0000_0100);
    ser_din_i = 1'b1;
    ser_clk_i = 1'b0;
    half_wait();
    ser_clk_i = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    half_wait();
    close_frame();
    do_read(3'd0, rd);
    check("R6 load beats tick", rd, 32'h0000_0100);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule